// File: doc/BRIEF.md
# DMA Command Queue Register Model

This block is a memory-mapped bank of 32-bit registers that stands in for the command queue of a DMA engine. Software sees the registers it expects and gets completion interrupts. No data is moved, no memory is accessed and no descriptors are parsed. Every write to the write-pointer register counts as an instant completion in both directions: upstream and downstream. The value written is also copied into the read-pointer register.

A special key value written to the read-pointer register arms a one-shot flag. The next write-pointer update then completes silently: no status bits are set and the interrupt line does not move. Completion status is reported as a pair of bits and is cleared as a pair. One registered, level-sensitive interrupt output stays high until software clears the status or the block is reset.

Software reaches the block through a simple single-cycle register bus. Accesses are full words only, the two low address bits are ignored, and the window is 4 KB. Offsets with no special behaviour are plain storage, up to the size of the implemented array. Offsets beyond the array read as zero and ignore writes. The parameter `NUM_REGS` must be at least 10, so that every special register lies inside the array.

Top module: `dma_cmdq_regs`

## Requirements
- R1: After reset, every register reads zero except the interrupt status register, which reads 0xF8000000. The armed flag is clear and `irq` is low.
- R2: Offsets with no special role inside the array, including the queue base at 0x10, store and return any 32-bit value unchanged.
- R3: Writes to the queue end register (0x14) and the write pointer register (0x18) keep only bits [17:0].
- R4: A write to the write pointer (0x18) also loads the same masked value into the read pointer (0x1C), in the same clock edge.
- R5: Writes to the read pointer (0x1C) never change its stored value. Writing exactly 0xEE882266 arms the one-shot flag. Any other value leaves the flag as it was.
- R6: A write-pointer write while the flag is armed disarms it and changes neither status bits 5:4 nor `irq`. The following write-pointer write signals normally.
- R7: A write-pointer write while the flag is not armed sets status bit 4 (upstream done) and bit 5 (downstream done). It raises `irq` on the next edge if control bit 4 or bit 5 is set; otherwise `irq` stays as it was.
- R8: Writes to the interrupt control register (0x20) are ANDed with 0xBFEFF07F before they are stored.
- R9: A write to the status register (0x24) whose data has bit 4 or bit 5 set clears both bits 5:4 and drops `irq`. All other status bits are never changed by writes. A write with neither bit set has no effect.
- R10: Word offsets at or beyond `NUM_REGS` read as zero, and writes to them change no register.
- R11: Once raised, `irq` stays high across unrelated writes until it is cleared through the status register or by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address within the window; bits [1:0] ignored |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Registered level completion interrupt |

## Verification
The bench builds the block with `NUM_REGS` set to 12, a 48-byte array. This puts the first out-of-range offset, 0x30, just past the status register at 0x24 and the spare word at 0x2C. The array edge and the window top (0xFFC) can then both be probed for reads of zero and for writes that must not alias into real registers. `ADDR_W` keeps its default of 12, so the full 4 KB window is reachable. The arming sequence, including a non-key write that must not disarm, is run with the interrupt enabled. A swallowed completion therefore shows up on `irq` as well as in the status bits.

// File: rtl/dma_cmdq_regs.sv
module dma_cmdq_regs #(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_REGS   = 64,
  parameter int          PTR_W      = 18,
  parameter int          UP_BIT     = 4,
  parameter int          DN_BIT     = 5,
  parameter logic [31:0] ARM_KEY    = 32'hEE88_2266,
  parameter logic [31:0] CTRL_WMASK = 32'hBFEF_F07F,
  parameter logic [31:0] STAT_INIT  = 32'hF800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int          IDX_W     = ADDR_W - 2;
  localparam int          SEL_W     = $clog2(NUM_REGS);
  localparam logic [31:0] PTR_MASK  = (32'd1 << PTR_W) - 32'd1;
  localparam logic [31:0] DONE_BITS = (32'd1 << UP_BIT) | (32'd1 << DN_BIT);
  localparam int I_END = 5, I_WP = 6, I_RP = 7, I_CTL = 8, I_ST = 9;

  logic [31:0] regs [NUM_REGS];
  logic        armed;

  wire [IDX_W-1:0] widx = bus_addr[ADDR_W-1:2];
  wire             hit  = int'(widx) < NUM_REGS;
  wire             wr   = bus_we && hit;
  wire [31:0]      ptr_in = bus_wdata & PTR_MASK;

  wire [31:0] ctl_q = regs[I_CTL];
  wire [31:0] st_q  = regs[I_ST];
  wire [31:0] wp_q  = regs[I_WP];
  wire [31:0] rp_q  = regs[I_RP];

  assign bus_rdata = hit ? regs[widx[SEL_W-1:0]] : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs[i] <= (i == I_ST) ? STAT_INIT : 32'd0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else if (wr) begin
      case (int'(widx))
        I_END: regs[I_END] <= ptr_in;
        I_WP: begin
          regs[I_WP] <= ptr_in;
          regs[I_RP] <= ptr_in;
          if (armed) begin
            armed <= 1'b0;
          end else begin
            regs[I_ST] <= st_q | DONE_BITS;
            if ((ctl_q & DONE_BITS) != 32'd0) irq <= 1'b1;
          end
        end
        I_RP: if (bus_wdata == ARM_KEY) armed <= 1'b1;
        I_CTL: regs[I_CTL] <= bus_wdata & CTRL_WMASK;
        I_ST: if ((bus_wdata & DONE_BITS) != 32'd0) begin
          regs[I_ST] <= st_q & ~DONE_BITS;
          irq        <= 1'b0;
        end
        default: regs[widx[SEL_W-1:0]] <= bus_wdata;
      endcase
    end
  end

  wire past_ok = rst_n;

  p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == IDX_W'(I_WP)) |=> (rp_q == wp_q));

  p_rp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == IDX_W'(I_RP)) |=> $stable(rp_q));

  p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == IDX_W'(I_WP) && armed) |=>
      (!armed && $stable(st_q[DN_BIT:UP_BIT]) && $stable(irq)));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == IDX_W'(I_WP) && !armed) |=> (st_q[DN_BIT] && st_q[UP_BIT]));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(past_ok && bus_we && widx == IDX_W'(I_WP) && (ctl_q[DN_BIT] || ctl_q[UP_BIT])));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == IDX_W'(I_ST) && (bus_wdata[UP_BIT] || bus_wdata[DN_BIT])) |=>
      (!irq && st_q[DN_BIT:UP_BIT] == 2'b00));

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(past_ok && bus_we && widx == IDX_W'(I_ST)));
endmodule

// File: tb/sim_dma_cmdq_regs.sv
module sim_dma_cmdq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq;

  always #5 clk = ~clk;

  dma_cmdq_regs #(.ADDR_W(12), .NUM_REGS(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  typedef struct {bit is_irq; logic [31:0] exp; string tag;} item_t;
  item_t sbq[$];
  item_t mon_it;
  int total = 0, bad = 0;
  logic rd_strobe = 1'b0;
  bit finished = 1'b0;
  logic [31:0] act;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic push(input bit k, input logic [11:0] a, input logic [31:0] e, input string t);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    it.is_irq = k; it.exp = e; it.tag = t;
    sbq.push_back(it);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    push(1'b0, a, e, t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    push(1'b1, bus_addr, {31'd0, e}, t);
  endtask

  always @(posedge clk) begin
    if (rd_strobe) begin
      #1;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty act=%h exp=item", bus_rdata);
      end else begin
        mon_it = sbq.pop_front();
        act = mon_it.is_irq ? {31'd0, irq} : bus_rdata;
        if (act !== mon_it.exp) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", mon_it.tag, act, mon_it.exp);
        end
      end
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog all requirements act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(12'h010, 32'h0, "R1 base reset");
    rd(12'h014, 32'h0, "R1 end reset");
    rd(12'h018, 32'h0, "R1 wptr reset");
    rd(12'h01C, 32'h0, "R1 rptr reset");
    rd(12'h020, 32'h0, "R1 ctrl reset");
    rd(12'h024, 32'hF800_0000, "R1 status reset");
    chk_irq(1'b0, "R1 irq reset");

    wr(12'h010, 32'hDEAD_BEEF); rd(12'h010, 32'hDEAD_BEEF, "R2 base storage");
    wr(12'h02C, 32'h1234_5678); rd(12'h02C, 32'h1234_5678, "R2 spare storage");
    wr(12'h000, 32'hA5A5_A5A5); rd(12'h000, 32'hA5A5_A5A5, "R2 word0 storage");

    wr(12'h014, 32'hFFFF_FFFF); rd(12'h014, 32'h0003_FFFF, "R3 end mask");
    wr(12'h018, 32'hFFF1_2345); rd(12'h018, 32'h0001_2345, "R3 wptr mask");
    rd(12'h01C, 32'h0001_2345, "R4 rptr mirror");
    rd(12'h024, 32'hF800_0030, "R7 status set");
    chk_irq(1'b0, "R7 no irq when disabled");

    wr(12'h024, 32'h0000_000F); rd(12'h024, 32'hF800_0030, "R9 write without done bits");
    wr(12'h024, 32'h0000_0020); rd(12'h024, 32'hF800_0000, "R9 pair cleared");

    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, 32'hBFEF_F07F, "R8 ctrl mask");
    wr(12'h020, 32'h0000_0010);

    wr(12'h01C, 32'h1111_1111); rd(12'h01C, 32'h0001_2345, "R5 rptr plain write");
    wr(12'h01C, 32'hEE88_2266); rd(12'h01C, 32'h0001_2345, "R5 rptr key write");
    wr(12'h01C, 32'h0000_0000);
    wr(12'h018, 32'h0000_0100);
    rd(12'h01C, 32'h0000_0100, "R4 mirror while armed");
    rd(12'h024, 32'hF800_0000, "R6 silent status");
    chk_irq(1'b0, "R6 silent irq");
    wr(12'h018, 32'h0000_0200);
    rd(12'h024, 32'hF800_0030, "R6 rearm consumed status");
    chk_irq(1'b1, "R7 irq raised bit4");

    wr(12'h010, 32'h0BAD_F00D); chk_irq(1'b1, "R11 irq holds over write");
    wr(12'h024, 32'h0000_0001); chk_irq(1'b1, "R11 irq holds no done bit");
    wr(12'h024, 32'h0000_0030); chk_irq(1'b0, "R9 irq dropped");
    rd(12'h024, 32'hF800_0000, "R9 status after clear");

    wr(12'h020, 32'h0000_0020);
    wr(12'h018, 32'h0000_0001); chk_irq(1'b1, "R7 irq raised bit5");
    wr(12'h024, 32'h0000_0010); chk_irq(1'b0, "R9 clear via bit4");

    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, 32'h0, "R10 edge reads zero");
    wr(12'hFFC, 32'hFFFF_FFFF); rd(12'hFFC, 32'h0, "R10 top reads zero");
    rd(12'h02C, 32'h1234_5678, "R10 no alias spare");
    rd(12'h000, 32'hA5A5_A5A5, "R10 no alias word0");
    rd(12'h024, 32'hF800_0000, "R10 status untouched");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule